// File: doc/BRIEF.md
# Dual-Phase Energy Pulse Generator

This block turns a stream of signed real-power samples into slow, active-low pulses on two outputs. The pulses take turns on the two outputs, so the pair can step a two-phase stepper counter directly. Each accepted sample adds its magnitude to an accumulator. Every time the accumulator reaches the threshold of the selected rate, one pulse is produced and the threshold is taken off the total.

A two-bit rate select picks one of four thresholds. The thresholds are a factor of two apart, which gives four full-scale pulse rates, each a power-of-two fraction of the clock. A no-load floor throws away samples that are too small, so a meter with no load does not creep forward.

The pulse width is set in microseconds and converted to clock cycles. When pulses come faster than twice that width allows, the width drops to half of the measured spacing between pulses. A minimum quiet time always separates the end of one pulse from the start of the next. When the supply-valid input is low, the block holds both outputs high and throws away its accumulated energy.

Top module: `energy_pulse_gen`

## Requirements
- R1: While `supply_ok` is low, or during reset, both outputs are high (inactive). A low `supply_ok` discards the accumulated total, and the next pulse after the supply returns goes out on `pulse_a_n`.
- R2: Only samples with `sample_vld` high are used. A sample contributes the absolute value of its two's-complement value, so a negative sample adds as much as a positive one of the same size.
- R3: The threshold is 2^(BASE_LOG2+3-`rate_sel`): `rate_sel` 0 is the slowest rate and 3 the fastest, each step doubling the rate. Each time the total reaches the threshold, one pulse is issued and the threshold is subtracted, with the remainder kept. Over a run, the pulse count equals floor(sum of accepted magnitudes / threshold).
- R4: A sample whose magnitude is below threshold >> CREEP_SHIFT is discarded, so a stream of such samples never produces a pulse.
- R5: Pulses alternate strictly. The first goes out on `pulse_a_n`, then `pulse_b_n`, and so on. The two outputs are never low at the same time.
- R6: A pulse stays low for PW = CLK_KHZ*PULSE_US/1000 cycles when it follows the previous pulse's falling edge by at least 2*PW cycles, or when it is the first pulse after reset or after a supply loss.
- R7: When the spacing d between a pulse's falling edge and the previous one is below 2*PW cycles, the pulse stays low for floor(d/2) cycles.
- R8: After a pulse ends, both outputs stay high for at least GAP = CLK_KHZ*GAP_US/1000 cycles before the next pulse starts.
- R9: A threshold crossing that happens while a pulse or its quiet time is still running is held back, not dropped. It is issued once the sequencer is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply-valid flag; low holds the block inactive |
| sample_vld | input | 1 | Qualifies `sample_pwr` in this cycle |
| sample_pwr | input | SAMPLE_W | Signed real-power sample |
| rate_sel | input | 2 | Full-scale rate select, 0 slowest to 3 fastest |
| pulse_a_n | output | 1 | First-phase active-low pulse output |
| pulse_b_n | output | 1 | Second-phase active-low pulse output |

## Verification
The assertions assume that reset is high from the first clock edge. They also assume that the accumulator never saturates. Saturation would lose energy but would break no property.

The bench exact pulse-count check needs two more things, and the bench provides both. First, `rate_sel` only changes while `supply_ok` is low, so the registered threshold and no-load floor have settled before any sample arrives. Second, each run stays small enough that the total stays far below saturation.

Random runs choose sample magnitudes from ranges that straddle the no-load floor and mix in invalid cycles. Some runs at the fastest rate push pulses close together, so that the halved-width rule and the held-back crossings both come into play.

// File: rtl/epg_pkg.sv
package epg_pkg;
  typedef enum logic {
    PH_A = 1'b0,
    PH_B = 1'b1
  } phase_e;

  function automatic int unsigned cycles_of(input int unsigned khz, input int unsigned us);
    int unsigned c;
    c = (khz * us) / 1000;
    return (c < 1) ? 1 : c;
  endfunction
endpackage

// File: rtl/epg_front.sv
// Sample conditioning: magnitude, validity and no-load floor, plus rate threshold.
module epg_front #(
  parameter int SAMPLE_W    = 16,
  parameter int BASE_LOG2   = 8,
  parameter int CREEP_SHIFT = 6,
  parameter int THR_W       = BASE_LOG2 + 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                supply_ok,
  input  logic                sample_vld,
  input  logic [SAMPLE_W-1:0] sample_pwr,
  input  logic [1:0]          rate_sel,
  output logic [SAMPLE_W-1:0] add_q,
  output logic [THR_W-1:0]    thr_q
);
  localparam int CMP_W = (THR_W > SAMPLE_W) ? THR_W : SAMPLE_W;

  logic [THR_W-1:0]    thr_tab [4];
  logic [SAMPLE_W-1:0] mag_c;
  logic [THR_W-1:0]    floor_c;
  logic                keep_c;

  for (genvar g = 0; g < 4; g++) begin : g_thr
    assign thr_tab[g] = THR_W'(1) << (BASE_LOG2 + 3 - g);
  end

  always_comb begin
    mag_c   = sample_pwr[SAMPLE_W-1] ? (~sample_pwr + SAMPLE_W'(1)) : sample_pwr;
    floor_c = thr_q >> CREEP_SHIFT;
    keep_c  = sample_vld && (mag_c != '0) && (CMP_W'(mag_c) >= CMP_W'(floor_c));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= thr_tab[0];
      add_q <= '0;
    end else begin
      thr_q <= thr_tab[rate_sel];
      add_q <= (supply_ok && keep_c) ? mag_c : '0;
    end
  end

  AST_CREEP_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (add_q != '0) |-> (CMP_W'(add_q) >= CMP_W'($past(thr_q) >> CREEP_SHIFT))); // R4
endmodule

// File: rtl/epg_accum.sv
// Energy accumulator: saturating add, fires when the threshold is reached and the sequencer is free.
module epg_accum #(
  parameter int SAMPLE_W = 16,
  parameter int THR_W    = 12,
  parameter int ACC_W    = 30
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                supply_ok,
  input  logic [SAMPLE_W-1:0] add,
  input  logic [THR_W-1:0]    thr,
  input  logic                ready,
  output logic                fire
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum_c;
  logic [ACC_W-1:0] next_c;

  always_comb begin
    fire  = ready && supply_ok && (acc_q >= ACC_W'(thr));
    sum_c = {1'b0, acc_q} + (ACC_W+1)'(add);
    if (fire) sum_c = sum_c - (ACC_W+1)'(thr);
    next_c = sum_c[ACC_W] ? '1 : sum_c[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || !supply_ok) acc_q <= '0;
    else                   acc_q <= next_c;
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(supply_ok) && !$past(fire)) |-> (acc_q >= $past(acc_q))); // R9
endmodule

// File: rtl/epg_phase_seq.sv
// Pulse sequencer: width selection, quiet time and output alternation.
module epg_phase_seq
  import epg_pkg::*;
#(
  parameter int PW_CYC  = 40,
  parameter int GAP_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic fire,
  output logic ready,
  output logic out_a_n,
  output logic out_b_n
);
  localparam int GAP_EFF = (GAP_CYC < 1) ? 1 : GAP_CYC;
  localparam int PW_W    = $clog2(PW_CYC + 1);
  localparam int INTV_W  = $clog2(2 * PW_CYC + 1) + 1;
  localparam int GAP_W   = $clog2(GAP_EFF + 1);

  logic              active_q;
  logic [PW_W-1:0]   rem_q;
  logic [GAP_W-1:0]  gap_q;
  logic [INTV_W-1:0] intv_q;
  phase_e            phase_q;
  logic [PW_W-1:0]   w_new;

  always_comb begin
    ready = !active_q && (gap_q == '0);
    if (intv_q >= INTV_W'(2 * PW_CYC)) w_new = PW_W'(PW_CYC);
    else if (intv_q < INTV_W'(2))      w_new = PW_W'(1);
    else                               w_new = PW_W'(intv_q >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst || !supply_ok) begin
      active_q <= 1'b0;
      rem_q    <= '0;
      gap_q    <= '0;
      intv_q   <= '1;
      phase_q  <= PH_A;
      out_a_n  <= 1'b1;
      out_b_n  <= 1'b1;
    end else begin
      if (fire)                intv_q <= INTV_W'(1);
      else if (intv_q != '1)   intv_q <= intv_q + INTV_W'(1);
      if (fire) begin
        active_q <= 1'b1;
        rem_q    <= w_new;
        phase_q  <= (phase_q == PH_A) ? PH_B : PH_A;
        if (phase_q == PH_A) out_a_n <= 1'b0;
        else                 out_b_n <= 1'b0;
      end else if (active_q) begin
        if (rem_q == PW_W'(1)) begin
          active_q <= 1'b0;
          out_a_n  <= 1'b1;
          out_b_n  <= 1'b1;
          gap_q    <= GAP_W'(GAP_EFF);
        end else begin
          rem_q <= rem_q - PW_W'(1);
        end
      end else if (gap_q != '0) begin
        gap_q <= gap_q - GAP_W'(1);
      end
    end
  end

  AST_WIDTH_BOUND: assert property (@(posedge clk) disable iff (rst)
    active_q |-> ((rem_q != '0) && (rem_q <= PW_W'(PW_CYC)))); // R6
  AST_QUIET_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    ($rose(out_a_n) || $rose(out_b_n)) |=> (out_a_n && out_b_n)); // R8
endmodule

// File: rtl/energy_pulse_gen.sv
module energy_pulse_gen #(
  parameter int SAMPLE_W    = 16,
  parameter int BASE_LOG2   = 8,
  parameter int CREEP_SHIFT = 6,
  parameter int CLK_KHZ     = 1000,
  parameter int PULSE_US    = 40,
  parameter int GAP_US      = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                supply_ok,
  input  logic                sample_vld,
  input  logic [SAMPLE_W-1:0] sample_pwr,
  input  logic [1:0]          rate_sel,
  output logic                pulse_a_n,
  output logic                pulse_b_n
);
  localparam int THR_W   = BASE_LOG2 + 4;
  localparam int ACC_W   = THR_W + SAMPLE_W + 2;
  localparam int PW_CYC  = int'(epg_pkg::cycles_of(CLK_KHZ, PULSE_US));
  localparam int GAP_CYC = int'(epg_pkg::cycles_of(CLK_KHZ, GAP_US));

  logic [SAMPLE_W-1:0] add_w;
  logic [THR_W-1:0]    thr_w;
  logic                fire_w;
  logic                ready_w;

  epg_front #(
    .SAMPLE_W(SAMPLE_W), .BASE_LOG2(BASE_LOG2),
    .CREEP_SHIFT(CREEP_SHIFT), .THR_W(THR_W)
  ) i_front (
    .clk(clk), .rst(rst), .supply_ok(supply_ok),
    .sample_vld(sample_vld), .sample_pwr(sample_pwr), .rate_sel(rate_sel),
    .add_q(add_w), .thr_q(thr_w)
  );

  epg_accum #(
    .SAMPLE_W(SAMPLE_W), .THR_W(THR_W), .ACC_W(ACC_W)
  ) i_accum (
    .clk(clk), .rst(rst), .supply_ok(supply_ok),
    .add(add_w), .thr(thr_w), .ready(ready_w), .fire(fire_w)
  );

  epg_phase_seq #(
    .PW_CYC(PW_CYC), .GAP_CYC(GAP_CYC)
  ) i_seq (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .fire(fire_w),
    .ready(ready_w), .out_a_n(pulse_a_n), .out_b_n(pulse_b_n)
  );

  AST_NEVER_BOTH_LOW: assert property (@(posedge clk) disable iff (rst)
    (pulse_a_n || pulse_b_n)); // R5
  AST_DORMANT: assert property (@(posedge clk) disable iff (rst)
    !$past(supply_ok) |-> (pulse_a_n && pulse_b_n)); // R1
endmodule

// File: tb/test_energy_pulse_gen.sv
module test_energy_pulse_gen;
  localparam int SW = 16;
  localparam int BASE = 8;
  localparam int CRS = 6;
  localparam int PW = 40;
  localparam int GAP = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0;
  logic sample_vld = 1'b0;
  logic [SW-1:0] sample_pwr = '0;
  logic [1:0] rate_sel = 2'd0;
  logic pulse_a_n, pulse_b_n;

  int n_chk = 0, n_fail = 0, cyc = 0, pulses = 0, n_short = 0;
  bit done = 0;

  energy_pulse_gen i_energy_pulse_gen (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .sample_vld(sample_vld),
    .sample_pwr(sample_pwr), .rate_sel(rate_sel),
    .pulse_a_n(pulse_a_n), .pulse_b_n(pulse_b_n)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int thr_of(input int sel);
    return 1 << (BASE + 3 - sel);
  endfunction

  function automatic int abs_of(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // Pulse monitor: alternation, widths, quiet time
  bit pa = 1, pb = 1, want_a = 1, have_fall = 0, have_rise = 0;
  int fall_t = 0, rise_t = 0, exp_w = 0;
  always @(negedge clk) begin
    if (rst || !supply_ok) begin
      pa = 1; pb = 1; want_a = 1; have_fall = 0; have_rise = 0;
    end else begin
      if (!pulse_a_n && !pulse_b_n) chk(0, "R5 both low", 0, 1);
      if ((pa && !pulse_a_n) || (pb && !pulse_b_n)) begin
        pulses++;
        chk((pa && !pulse_a_n) == want_a, "R5 alternation", int'(!pulse_a_n), int'(want_a));
        if (have_rise) chk(cyc - rise_t >= GAP, "R8 quiet time", cyc - rise_t, GAP);
        if (have_fall && (cyc - fall_t) < 2 * PW) exp_w = (cyc - fall_t) / 2;
        else exp_w = PW;
        fall_t = cyc; have_fall = 1; want_a = !want_a;
      end
      if ((!pa && pulse_a_n) || (!pb && pulse_b_n)) begin
        if (exp_w < PW) begin
          n_short++;
          chk(cyc - fall_t == exp_w, "R7 short width", cyc - fall_t, exp_w);
        end else begin
          chk(cyc - fall_t == exp_w, "R6 nominal width", cyc - fall_t, exp_w);
        end
        rise_t = cyc; have_rise = 1;
      end
      pa = pulse_a_n; pb = pulse_b_n;
    end
  end

  task automatic drive(input bit v, input int val);
    @(posedge clk); #1;
    sample_vld = v;
    sample_pwr = SW'(val);
  endtask

  task automatic power_cycle(input int sel);
    @(posedge clk); #1;
    supply_ok = 0; sample_vld = 0; rate_sel = 2'(sel);
    repeat (4) @(posedge clk);
    #1;
    chk(pulse_a_n && pulse_b_n, "R1 idle without supply", int'({pulse_a_n, pulse_b_n}), 3);
    supply_ok = 1;
  endtask

  // mode 0: random mix, 1: all below floor, 2: invalid cycles only, 3: negatives only
  task automatic run_case(input int sel, input int n, input int mode, input int maxmag, input string req);
    int sum = 0, start, exp_p, thr, flo, wait_c;
    thr = thr_of(sel); flo = thr >> CRS;
    power_cycle(sel);
    start = pulses;
    for (int i = 0; i < n; i++) begin
      bit v; int m, val;
      case (mode)
        1: begin v = 1; m = int'($urandom_range(flo - 1, 0)); end
        2: begin v = 0; m = int'($urandom_range(maxmag, 1)); end
        default: begin v = ($urandom_range(3, 0) != 0); m = int'($urandom_range(maxmag, 0)); end
      endcase
      val = (mode == 3 || $urandom_range(1, 0) == 1) ? -m : m;
      if (v && abs_of(val) >= flo && val != 0) sum += abs_of(val);
      drive(v, val);
    end
    drive(0, 0);
    exp_p = sum / thr;
    wait_c = 0;
    while ((pulses - start) < exp_p && wait_c < exp_p * (PW + GAP + 4) + 400) begin
      @(posedge clk); wait_c++;
    end
    repeat (3 * PW) @(posedge clk);
    chk(pulses - start == exp_p, req, pulses - start, exp_p);
  endtask

  initial begin
    int r;
    r = $urandom(5813);
    repeat (3) @(posedge clk);
    #1;
    chk(pulse_a_n && pulse_b_n, "R1 reset state", int'({pulse_a_n, pulse_b_n}), 3);
    rst = 0;
    run_case(0, 500, 0, 700, "R3 count rate 0");
    run_case(1, 400, 0, 600, "R3 count rate 1");
    run_case(2, 300, 0, 400, "R3 count rate 2");
    run_case(3, 200, 0, 1500, "R9 count rate 3 busy");
    run_case(3, 400, 1, 0, "R4 below floor rate 3");
    run_case(0, 400, 1, 0, "R4 below floor rate 0");
    run_case(1, 300, 2, 3000, "R2 invalid ignored");
    run_case(2, 200, 3, 500, "R2 negative magnitude");
    // R1: supply loss discards accumulated energy
    begin
      int start;
      power_cycle(3);
      start = pulses;
      drive(1, 200); drive(0, 0);
      power_cycle(3);
      drive(1, -100); drive(0, 0);
      repeat (3 * PW) @(posedge clk);
      chk(pulses == start, "R1 total cleared", pulses - start, 0);
      // exact threshold gives one pulse on output A after the supply returns
      drive(1, 156); drive(0, 0);
      repeat (3 * PW) @(posedge clk);
      chk(pulses - start == 1, "R1 restart on A", pulses - start, 1);
    end
    // R3: exact remainder kept across many small samples
    begin
      int start;
      power_cycle(0);
      start = pulses;
      for (int i = 0; i < 63; i++) drive(1, 32);
      drive(0, 0);
      repeat (3 * PW) @(posedge clk);
      chk(pulses == start, "R3 one below threshold", pulses - start, 0);
      drive(1, 32); drive(0, 0);
      repeat (3 * PW) @(posedge clk);
      chk(pulses - start == 1, "R3 threshold reached", pulses - start, 1);
    end
    chk(n_short > 0, "R7 short widths exercised", n_short, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule